// File: doc/BRIEF.md
# Per-Hart Direct Interrupt Delivery Controller

This block turns a set of interrupt source states into one wired interrupt line per hart. Each source arrives as a pending bit, an enable bit, a raw input level, two trigger-kind flags and a target word made of a hart index and a priority. For every hart the controller looks at the sources that are pending, enabled and aimed at that hart, applies the hart's priority threshold, and selects the winner. A numerically smaller priority is more urgent.

Software reaches a small register block per hart. It holds a delivery enable, a force bit and a threshold, plus two read-only views of the current winner: one view only reports it, the other claims it. A claim does not change pending state directly. It emits a one-cycle acknowledge pulse that names the source and says whether the owner of the pending bits should set the bit again after clearing it. The owner must set it again when a level-triggered input is still active.

Top module: `hart_delivery_ctrl`

## Requirements
- R1: Each hart owns a 32-byte register window whose base is hart index × 32. The offsets are: delivery enable at 0x00, force at 0x04, threshold at 0x08, top value at 0x18 and claim at 0x1C. Delivery enable and force store only bit 0. The threshold stores only its low PRIO_W bits. The writable registers read back what they stored.
- R2: A source is a candidate for hart h only when its pending and enable bits are both 1 and its target hart index equals h. Source 0 is never a candidate.
- R3: When a hart's threshold is nonzero, candidates whose priority is greater than or equal to the threshold are dropped. A threshold of 0 drops nothing.
- R4: Among the remaining candidates, the smallest priority number wins. On a tie, the smallest source number wins.
- R5: The top value is (source number << 16) | priority when a winner exists, and 0 otherwise. A target priority field of 0 is treated as priority 1.
- R6: The hart line goes to 1 one clock after the following holds: the domain enable input is 1, delivery enable is 1, and either force is 1 or a winner exists. In every other case the line goes to 0 after the same delay.
- R7: A claim read returns the top value one clock after the read strobe. When a winner exists, the block raises ack_valid for exactly that one cycle, with ack_src set to the winning source. There is one pulse per strobe.
- R8: On a claim acknowledge, ack_repend is 1 when the source is level-high with its input at 1, or level-low with its input at 0. Otherwise ack_repend is 0.
- R9: A claim read with no winner returns 0, raises no acknowledge and clears that hart's force bit.
- R10: A top-value read returns the same value as a claim would. It raises no acknowledge and leaves force unchanged.
- R11: Reads of hart windows at or above NUM_HART, or of unassigned offsets, return 0. Writes to them change no register.
- R12: After reset, every register is 0 and all hart lines are 0. reg_rdata is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| domain_en | input | 1 | Domain-wide interrupt enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after reg_rd |
| src_pend | input | NUM_SRC | Pending bit per source |
| src_en | input | NUM_SRC | Enable bit per source |
| src_in | input | NUM_SRC | Raw input level per source |
| src_lvl_hi | input | NUM_SRC | Source is level-high triggered |
| src_lvl_lo | input | NUM_SRC | Source is level-low triggered |
| src_hart | input | NUM_SRC*HART_W | Target hart index per source |
| src_prio | input | NUM_SRC*PRIO_W | Target priority per source |
| hart_irq | output | NUM_HART | Registered interrupt line per hart |
| ack_valid | output | 1 | Claim acknowledge pulse |
| ack_src | output | SRC_W | Claimed source number |
| ack_repend | output | 1 | Owner must set the pending bit again |

## Verification
The bench sweeps many pseudo-random source patterns against an arithmetic model. It targets the cases where a threshold of 0 must still admit every candidate, and where a candidate whose priority equals the threshold must be dropped. A design that compares with the wrong inequality, or that treats threshold 0 as "nothing passes", reports the wrong winner or silences the hart line. Priority ties catch an arbiter that lets later sources override earlier ones. Claims of still-asserted level-high and level-low sources, and of edge sources, catch a wrong ack_repend. An empty claim must clear force, so a design that skips this leaves the hart line stuck high. A design that claims on top-value reads shows up as an extra acknowledge.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam logic [4:0] OFS_DELIV  = 5'h00;
  localparam logic [4:0] OFS_FORCE  = 5'h04;
  localparam logic [4:0] OFS_THRESH = 5'h08;
  localparam logic [4:0] OFS_TOP    = 5'h18;
  localparam logic [4:0] OFS_CLAIM  = 5'h1C;
  localparam int         ID_SHIFT   = 16;

  function automatic int width_of(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hdc_arbiter.sv
module hdc_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  parameter int HART_W  = 2,
  parameter int SRC_W   = 5,
  parameter int HART_ID = 0
) (
  input  logic [NUM_SRC-1:0]        live,
  input  logic [NUM_SRC*HART_W-1:0] tgt_hart,
  input  logic [NUM_SRC*PRIO_W-1:0] tgt_prio,
  input  logic [PRIO_W-1:0]         thresh,
  output logic                      found,
  output logic [SRC_W-1:0]          win_src,
  output logic [PRIO_W-1:0]         win_prio
);
  localparam logic [HART_W-1:0] MY_ID = HART_W'(HART_ID);

  // Ascending scan with strict compare keeps the lowest number on ties.
  always_comb begin
    found    = 1'b0;
    win_src  = '0;
    win_prio = '1;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (live[s] && (tgt_hart[s*HART_W +: HART_W] == MY_ID) &&
          ((thresh == '0) || (tgt_prio[s*PRIO_W +: PRIO_W] < thresh)) &&
          (!found || (tgt_prio[s*PRIO_W +: PRIO_W] < win_prio))) begin
        found    = 1'b1;
        win_src  = SRC_W'(s);
        win_prio = tgt_prio[s*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/hdc_hart_regs.sv
module hdc_hart_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_deliv,
  input  logic              wr_force,
  input  logic              wr_thresh,
  input  logic              clr_force,
  input  logic [31:0]       wdata,
  output logic              deliv,
  output logic              frc,
  output logic [PRIO_W-1:0] thresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      deliv  <= 1'b0;
      frc    <= 1'b0;
      thresh <= '0;
    end else begin
      if (wr_deliv)       deliv <= wdata[0];
      if (clr_force)      frc   <= 1'b0;
      else if (wr_force)  frc   <= wdata[0];
      if (wr_thresh)      thresh <= wdata[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/hart_delivery_ctrl.sv
module hart_delivery_ctrl #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 4,
  parameter int PRIO_W   = 8,
  parameter int ADDR_W   = 12,
  parameter int HART_W   = hdc_pkg::width_of(NUM_HART),
  parameter int SRC_W    = hdc_pkg::width_of(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      domain_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_SRC-1:0]        src_pend,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_in,
  input  logic [NUM_SRC-1:0]        src_lvl_hi,
  input  logic [NUM_SRC-1:0]        src_lvl_lo,
  input  logic [NUM_SRC*HART_W-1:0] src_hart,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  output logic [NUM_HART-1:0]       hart_irq,
  output logic                      ack_valid,
  output logic [SRC_W-1:0]          ack_src,
  output logic                      ack_repend
);
  import hdc_pkg::*;

  localparam int HSEL_W = ADDR_W - 5;

  logic [NUM_SRC*PRIO_W-1:0] prio_n;
  logic [NUM_SRC-1:0]        live;
  logic [HSEL_W-1:0]         hsel;
  logic [4:0]                ofs;
  logic                      in_range;

  logic              deliv_q  [NUM_HART];
  logic              frc_q    [NUM_HART];
  logic [PRIO_W-1:0] thr_q    [NUM_HART];
  logic              found    [NUM_HART];
  logic [SRC_W-1:0]  win_src  [NUM_HART];
  logic [PRIO_W-1:0] win_prio [NUM_HART];
  logic [31:0]       top_word [NUM_HART];

  assign live     = src_pend & src_en;
  assign hsel     = reg_addr[ADDR_W-1:5];
  assign ofs      = reg_addr[4:0];
  assign in_range = (int'(hsel) < NUM_HART);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
    assign prio_n[s*PRIO_W +: PRIO_W] =
      (src_prio[s*PRIO_W +: PRIO_W] == '0) ? PRIO_W'(1) : src_prio[s*PRIO_W +: PRIO_W];
  end

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    logic sel;
    assign sel = in_range && (int'(hsel) == h);

    hdc_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .HART_W(HART_W),
      .SRC_W(SRC_W), .HART_ID(h)
    ) arb_i (
      .live(live), .tgt_hart(src_hart), .tgt_prio(prio_n),
      .thresh(thr_q[h]), .found(found[h]),
      .win_src(win_src[h]), .win_prio(win_prio[h])
    );

    assign top_word[h] = found[h]
      ? ((32'(win_src[h]) << ID_SHIFT) | 32'(win_prio[h])) : 32'd0;

    hdc_hart_regs #(.PRIO_W(PRIO_W)) regs_i (
      .clk(clk), .rst(rst),
      .wr_deliv (reg_wr && sel && (ofs == OFS_DELIV)),
      .wr_force (reg_wr && sel && (ofs == OFS_FORCE)),
      .wr_thresh(reg_wr && sel && (ofs == OFS_THRESH)),
      .clr_force(reg_rd && sel && (ofs == OFS_CLAIM) && !found[h]),
      .wdata(reg_wdata),
      .deliv(deliv_q[h]), .frc(frc_q[h]), .thresh(thr_q[h])
    );

    always_ff @(posedge clk) begin
      if (rst) hart_irq[h] <= 1'b0;
      else     hart_irq[h] <= domain_en && deliv_q[h] && (frc_q[h] || found[h]);
    end
  end

  logic [31:0]      rd_mux;
  logic             claim_hit;
  logic [SRC_W-1:0] claim_src;
  logic             claim_rep;

  always_comb begin
    rd_mux    = '0;
    claim_hit = 1'b0;
    claim_src = '0;
    for (int h = 0; h < NUM_HART; h++) begin
      if (in_range && (int'(hsel) == h)) begin
        case (ofs)
          OFS_DELIV:  rd_mux = {31'd0, deliv_q[h]};
          OFS_FORCE:  rd_mux = {31'd0, frc_q[h]};
          OFS_THRESH: rd_mux = 32'(thr_q[h]);
          OFS_TOP:    rd_mux = top_word[h];
          OFS_CLAIM: begin
            rd_mux    = top_word[h];
            claim_hit = found[h];
            claim_src = win_src[h];
          end
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  assign claim_rep = (src_lvl_hi[claim_src] &&  src_in[claim_src]) ||
                     (src_lvl_lo[claim_src] && !src_in[claim_src]);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      ack_valid  <= 1'b0;
      ack_src    <= '0;
      ack_repend <= 1'b0;
    end else begin
      reg_rdata  <= reg_rd ? rd_mux : 32'd0;
      ack_valid  <= reg_rd && claim_hit;
      ack_src    <= (reg_rd && claim_hit) ? claim_src : '0;
      ack_repend <= reg_rd && claim_hit && claim_rep;
    end
  end
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 4,
  parameter int ADDR_W   = 12,
  parameter int SRC_W    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                domain_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_rd,
  input logic [31:0]         reg_rdata,
  input logic [NUM_HART-1:0] hart_irq,
  input logic                ack_valid,
  input logic [SRC_W-1:0]    ack_src
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7
  ack_after_claim_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ack_valid |-> ($past(reg_rd) && ($past(reg_addr[4:0]) == 5'h1C)));

  // R7
  ack_src_range_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ack_valid |-> ((ack_src != '0) && (int'(ack_src) < NUM_SRC)));

  // R6
  irq_needs_domain_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(domain_en) |-> (hart_irq == '0));

  // R12
  quiet_rdata_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(reg_rd) |-> (reg_rdata == 32'd0));

  // R11
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(reg_rd) && (int'($past(reg_addr[ADDR_W-1:5])) >= NUM_HART)) |-> (reg_rdata == 32'd0));
endmodule

bind hart_delivery_ctrl hdc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
) chk_i (
  .clk(clk), .rst(rst), .domain_en(domain_en), .reg_addr(reg_addr),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .hart_irq(hart_irq),
  .ack_valid(ack_valid), .ack_src(ack_src)
);

// File: tb/hart_delivery_ctrl_tb_top.sv
module hart_delivery_ctrl_tb_top;
  localparam int NS = 8, NH = 2, PW = 3, AW = 7, HW = 1, SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic domain_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] src_pend = '0, src_en = '0, src_in = '0, src_lvl_hi = '0, src_lvl_lo = '0;
  logic [NS*HW-1:0] src_hart = '0;
  logic [NS*PW-1:0] src_prio = '0;
  logic [NH-1:0] hart_irq;
  logic ack_valid, ack_repend;
  logic [SW-1:0] ack_src;

  int n_tests = 0, n_fail = 0;
  logic a_v, a_r;
  logic [SW-1:0] a_s;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] d;

  always #5 clk = ~clk;

  hart_delivery_ctrl #(.NUM_SRC(NS), .NUM_HART(NH), .PRIO_W(PW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .domain_en(domain_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_pend(src_pend), .src_en(src_en), .src_in(src_in),
    .src_lvl_hi(src_lvl_hi), .src_lvl_lo(src_lvl_lo),
    .src_hart(src_hart), .src_prio(src_prio), .hart_irq(hart_irq),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_repend(ack_repend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int h, input logic [4:0] o, input logic [31:0] v);
    @(negedge clk);
    reg_addr = AW'(h * 32 + int'(o)); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int h, input logic [4:0] o, output logic [31:0] v);
    @(negedge clk);
    reg_addr = AW'(h * 32 + int'(o)); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata; a_v = ack_valid; a_s = ack_src; a_r = ack_repend;
  endtask

  function automatic logic [31:0] model_top(input int h, input int thr);
    int bs = 0;
    int bp = 99;
    for (int s = 1; s < NS; s++) begin
      int p;
      p = (src_prio[s*PW +: PW] == '0) ? 1 : int'(src_prio[s*PW +: PW]);
      if (src_pend[s] && src_en[s] && (int'(src_hart[s*HW +: HW]) == h) &&
          ((thr == 0) || (p < thr)) && (p < bp)) begin
        bp = p; bs = s;
      end
    end
    return (bs == 0) ? 32'd0 : ((32'(bs) << 16) | 32'(bp));
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    for (int h = 0; h < NH; h++) begin
      rd(h, 5'h00, d); check("R12 deliv reset", d, 0);
      rd(h, 5'h04, d); check("R12 force reset", d, 0);
      rd(h, 5'h08, d); check("R12 thresh reset", d, 0);
    end
    check("R12 irq reset", 32'(hart_irq), 0);

    // R1 storage widths
    wr(0, 5'h00, 32'hFFFF_FFFF); rd(0, 5'h00, d); check("R1 deliv bit0", d, 1);
    wr(0, 5'h04, 32'hFFFF_FFFE); rd(0, 5'h04, d); check("R1 force bit0", d, 0);
    wr(1, 5'h08, 32'h0000_00FF); rd(1, 5'h08, d); check("R1 thresh width", d, 7);
    wr(1, 5'h08, 32'h0); 

    // R11 out of range and unassigned
    wr(3, 5'h04, 32'h1); wr(1, 5'h0C, 32'h1);
    rd(1, 5'h04, d); check("R11 hart1 force untouched", d, 0);
    rd(0, 5'h04, d); check("R11 hart0 force untouched", d, 0);
    rd(2, 5'h00, d); check("R11 oob read", d, 0);
    rd(0, 5'h0C, d); check("R11 unassigned read", d, 0);

    // R6 force path
    domain_en = 1'b1;
    wr(0, 5'h04, 32'h1); @(negedge clk);
    check("R6 force raises irq", 32'(hart_irq[0]), 1);
    wr(0, 5'h00, 32'h0); @(negedge clk);
    check("R6 deliv off lowers irq", 32'(hart_irq[0]), 0);
    // R10 top read has no side effects; R9 empty claim clears force
    rd(0, 5'h18, d); check("R10 empty top", d, 0);
    check("R10 no ack on top", 32'(a_v), 0);
    rd(0, 5'h04, d); check("R10 force kept", d, 1);
    rd(0, 5'h1C, d); check("R9 empty claim data", d, 0);
    check("R9 empty claim no ack", 32'(a_v), 0);
    rd(0, 5'h04, d); check("R9 force cleared", d, 0);

    // R2..R6 sweep
    wr(0, 5'h00, 32'h1); wr(1, 5'h00, 32'h1);
    for (int it = 0; it < 150; it++) begin
      int t0, t1;
      seed = xs(seed);
      src_pend = seed[7:0]; src_en = seed[15:8]; src_hart = seed[23:16];
      domain_en = seed[24];
      t0 = (it % 3 == 0) ? 0 : int'(seed[27:25]);
      t1 = (it % 4 == 0) ? 0 : int'(seed[30:28]);
      seed = xs(seed);
      src_prio = seed[23:0];
      if (it % 5 == 0) src_prio[2*PW +: PW] = '0;
      wr(0, 5'h08, 32'(t0)); wr(1, 5'h08, 32'(t1));
      rd(0, 5'h18, d); check("R2 R3 R4 R5 top hart0", d, model_top(0, t0));
      check("R10 top read no ack", 32'(a_v), 0);
      rd(1, 5'h18, d); check("R2 R3 R4 R5 top hart1", d, model_top(1, t1));
      check("R6 irq hart0", 32'(hart_irq[0]), 32'(domain_en && (model_top(0, t0) != 0)));
      check("R6 irq hart1", 32'(hart_irq[1]), 32'(domain_en && (model_top(1, t1) != 0)));
    end

    // R7 R8 claims
    domain_en = 1'b1;
    wr(0, 5'h08, 32'h0);
    src_pend = 8'b0110_1000; src_en = 8'hFF; src_hart = 8'h00;
    src_prio = '0;
    src_prio[3*PW +: PW] = 3'd2; src_prio[5*PW +: PW] = 3'd2; src_prio[6*PW +: PW] = 3'd4;
    src_lvl_hi = 8'b0000_1000; src_lvl_lo = 8'b0100_0000;
    src_in = 8'b0000_1000;
    rd(0, 5'h1C, d); check("R7 claim tie data", d, (32'd3 << 16) | 32'd2);
    check("R7 ack", 32'(a_v), 1); check("R7 ack src", 32'(a_s), 3);
    check("R8 level-high still high", 32'(a_r), 1);
    @(negedge clk); check("R7 single pulse", 32'(ack_valid), 0);
    src_in[3] = 1'b0;
    rd(0, 5'h1C, d); check("R7 claim again", d, (32'd3 << 16) | 32'd2);
    check("R8 level-high dropped", 32'(a_r), 0);
    src_pend[3] = 1'b0;
    rd(0, 5'h1C, d); check("R7 claim edge src", 32'(a_s), 5);
    check("R8 edge no repend", 32'(a_r), 0);
    src_pend[5] = 1'b0;
    rd(0, 5'h1C, d); check("R7 claim level-low", d, (32'd6 << 16) | 32'd4);
    check("R8 level-low input low", 32'(a_r), 1);
    src_in[6] = 1'b1;
    rd(0, 5'h1C, d); check("R8 level-low input high", 32'(a_r), 0);
    src_pend[6] = 1'b0;
    rd(0, 5'h1C, d); check("R9 nothing left", 32'(a_v), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule